// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Integer Core

This block is a small 32-bit integer core that runs a seven-instruction subset of the base RISC-V integer set: `add`, `addi`, `lw`, `sw`, `beq`, `jal` and `jalr`. Each instruction finishes in a single clock. In that one cycle the core fetches the word at the current program counter, decodes it, reads two source registers, forms an address or a sum, may read or write data memory, may write one destination register, and selects the next program counter.

Both memories sit outside the block. The instruction port is a combinational read: the core drives the program counter as a byte address and expects the instruction word back in the same cycle. The data port carries an address, store data and a write strobe, and it takes load data back combinationally. A store is committed by the memory on the rising clock edge. The memory uses only byte-address bits above bit 1, so every access is treated as word aligned. Immediates follow the standard formats, including the permuted bit layouts of the branch and jump formats. Any word outside the subset runs as a no-op.

Top module: `rvs_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter is loaded with 0, and `imem_addr` shows 0 after that edge.
- R2: `add` (opcode 0110011, funct3 000, bits 31:25 all zero) writes rs1 + rs2 to rd. `addi` (opcode 0010011, funct3 000) writes rs1 + I-imm to rd. The I-imm is bits 31:20 sign-extended from bit 31. Fields: rd = bits 11:7, rs1 = bits 19:15, rs2 = bits 24:20.
- R3: `lw` (opcode 0000011, funct3 010) drives `dmem_addr` = rs1 + I-imm and writes the returned word to rd. The memory ignores address bits 1:0.
- R4: `sw` (opcode 0100011, funct3 010) raises `dmem_we` for that cycle and drives `dmem_addr` = rs1 + S-imm and `dmem_wdata` = rs2. The S-imm is {bits 31:25, bits 11:7}, sign-extended. No register is written.
- R5: `beq` (opcode 1100011, funct3 000) sets the next PC to PC + B-imm when rs1 equals rs2, and to PC + 4 otherwise. The B-imm is {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended.
- R6: `jal` (opcode 1101111) writes PC + 4 to rd and sets the next PC to PC + J-imm. The J-imm is {bit 31, bits 19:12, bit 20, bits 30:21, 0}, sign-extended.
- R7: `jalr` (opcode 1100111, funct3 000) writes PC + 4 to rd and sets the next PC to rs1 + I-imm with bit 0 cleared.
- R8: Register x0 always reads as zero, and any write to it is discarded.
- R9: Any other instruction word, including the listed opcodes with other funct3 or funct7 values, writes no register, keeps `dmem_we` low, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The memory-side outputs (`dmem_addr`, `dmem_wdata`, `dmem_we`) are combinational in the current instruction, so the bench samples them at the falling edge of the cycle in which that instruction is presented. The next PC and any register write take effect at the following rising edge. The bench therefore checks `imem_addr` against the model's PC at the next falling edge. A written register has no port of its own, so its value is checked later, when a store places it on `dmem_wdata`. Each such check is tagged with the requirement of the instruction that last wrote that register.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;

   typedef enum logic [2:0] {
      IMMK_I, IMMK_S, IMMK_B, IMMK_J, IMMK_NONE
   } imm_kind_e;

   typedef enum logic [1:0] {
      WBK_SUM, WBK_LOAD, WBK_LINK
   } wb_kind_e;

   typedef enum logic [1:0] {
      NPK_SEQ, NPK_BRANCH, NPK_JAL, NPK_JALR
   } npc_kind_e;

   typedef struct packed {
      logic      reg_wr;
      logic      mem_wr;
      logic      use_imm;
      wb_kind_e  wb_kind;
      npc_kind_e npc_kind;
      imm_kind_e imm_kind;
   } ctrl_t;

endpackage

// File: rtl/rvs_regfile.sv
module rvs_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int NRD  = 2,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [XLEN-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]    raddr,
   output logic [NRD-1:0][XLEN-1:0]  rdata
);

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("rvs_regfile: NREG must be a power of two, at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("rvs_regfile: at least one read port is needed");
   end

   logic [XLEN-1:0] cell_q [NREG];

   always_ff @(posedge clk) begin
      if (we && waddr != '0) begin
         cell_q[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rport
      assign rdata[p] = (raddr[p] == '0) ? '0 : cell_q[raddr[p]];
   end

   // R2: a committed write is returned by port 0 in the next cycle
   a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
      (we && waddr != '0) |=> ((raddr[0] == $past(waddr)) -> (rdata[0] == $past(wdata))));

   // R8: a write aimed at x0 leaves x0 reading zero
   a_r8_x0_stays_zero: assert property (@(posedge clk) disable iff (rst)
      (we && waddr == '0) |=> ((raddr[0] == '0) -> (rdata[0] == '0)));

endmodule

// File: rtl/rvs_immgen.sv
module rvs_immgen
   import rvs_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     inst,
   input  imm_kind_e       kind,
   output logic [XLEN-1:0] imm
);

   if (XLEN < 32) begin : g_bad_xlen
      $error("rvs_immgen: XLEN below 32 cannot hold a jump offset");
   end

   localparam int EXT_I = XLEN - 12;
   localparam int EXT_B = XLEN - 13;
   localparam int EXT_J = XLEN - 21;

   logic sgn;
   assign sgn = inst[31];

   always_comb begin
      case (kind)
         IMMK_I:  imm = {{EXT_I{sgn}}, inst[31:20]};
         IMMK_S:  imm = {{EXT_I{sgn}}, inst[31:25], inst[11:7]};
         IMMK_B:  imm = {{EXT_B{sgn}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
         IMMK_J:  imm = {{EXT_J{sgn}}, inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
         default: imm = '0;
      endcase
   end

endmodule

// File: rtl/rvs_decoder.sv
module rvs_decoder
   import rvs_pkg::*;
(
   input  logic [31:0] inst,
   output ctrl_t       ctrl
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;

   assign opc = inst[6:0];
   assign f3  = inst[14:12];
   assign f7  = inst[31:25];

   always_comb begin
      ctrl          = '0;
      ctrl.wb_kind  = WBK_SUM;
      ctrl.npc_kind = NPK_SEQ;
      ctrl.imm_kind = IMMK_NONE;
      case (opc)
         OPC_REG: if (f3 == 3'b000 && f7 == 7'b0) begin
            ctrl.reg_wr = 1'b1;
         end
         OPC_IMM: if (f3 == 3'b000) begin
            ctrl.reg_wr   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.imm_kind = IMMK_I;
         end
         OPC_LOAD: if (f3 == 3'b010) begin
            ctrl.reg_wr   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.wb_kind  = WBK_LOAD;
            ctrl.imm_kind = IMMK_I;
         end
         OPC_STORE: if (f3 == 3'b010) begin
            ctrl.mem_wr   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.imm_kind = IMMK_S;
         end
         OPC_BRANCH: if (f3 == 3'b000) begin
            ctrl.npc_kind = NPK_BRANCH;
            ctrl.imm_kind = IMMK_B;
         end
         OPC_JAL: begin
            ctrl.reg_wr   = 1'b1;
            ctrl.wb_kind  = WBK_LINK;
            ctrl.npc_kind = NPK_JAL;
            ctrl.imm_kind = IMMK_J;
         end
         OPC_JALR: if (f3 == 3'b000) begin
            ctrl.reg_wr   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.wb_kind  = WBK_LINK;
            ctrl.npc_kind = NPK_JALR;
            ctrl.imm_kind = IMMK_I;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rvs_alu.sv
module rvs_alu #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] cmpx,
   input  logic [XLEN-1:0] cmpy,
   output logic [XLEN-1:0] sum,
   output logic            same
);

   assign sum  = opa + opb;
   assign same = (cmpx == cmpy);

endmodule

// File: rtl/rvs_core.sv
module rvs_core
   import rvs_pkg::*;
#(
   parameter int               XLEN     = 32,
   parameter int               NREG     = 32,
   parameter logic [XLEN-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);

   localparam int RAW = $clog2(NREG);
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   if (XLEN != 32) begin : g_bad_xlen
      $error("rvs_core: the instruction subset defines a 32-bit datapath");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("rvs_core: five-bit register fields need exactly 32 registers");
   end

   logic [XLEN-1:0] pc_q, pc_d;
   ctrl_t           ctrl;
   logic [XLEN-1:0] imm, rs1_v, rs2_v, alu_b, sum, wb_v;
   logic [XLEN-1:0] pc_seq, pc_rel;
   logic            same;
   logic            rf_we;
   logic [1:0][RAW-1:0]  rf_ra;
   logic [1:0][XLEN-1:0] rf_rd;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_d;
   end

   assign imem_addr = pc_q;

   rvs_decoder u_dec (
      .inst (imem_rdata),
      .ctrl (ctrl)
   );

   rvs_immgen #(.XLEN(XLEN)) u_imm (
      .inst (imem_rdata),
      .kind (ctrl.imm_kind),
      .imm  (imm)
   );

   assign rf_ra[0] = imem_rdata[19:15];
   assign rf_ra[1] = imem_rdata[24:20];
   assign rf_we    = ctrl.reg_wr;

   rvs_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we),
      .waddr (imem_rdata[11:7]),
      .wdata (wb_v),
      .raddr (rf_ra),
      .rdata (rf_rd)
   );

   assign rs1_v = rf_rd[0];
   assign rs2_v = rf_rd[1];
   assign alu_b = ctrl.use_imm ? imm : rs2_v;

   rvs_alu #(.XLEN(XLEN)) u_alu (
      .opa  (rs1_v),
      .opb  (alu_b),
      .cmpx (rs1_v),
      .cmpy (rs2_v),
      .sum  (sum),
      .same (same)
   );

   assign pc_seq = pc_q + STEP;
   assign pc_rel = pc_q + imm;

   always_comb begin
      case (ctrl.wb_kind)
         WBK_LOAD: wb_v = dmem_rdata;
         WBK_LINK: wb_v = pc_seq;
         default:  wb_v = sum;
      endcase
   end

   always_comb begin
      case (ctrl.npc_kind)
         NPK_BRANCH: pc_d = same ? pc_rel : pc_seq;
         NPK_JAL:    pc_d = pc_rel;
         NPK_JALR:   pc_d = {sum[XLEN-1:1], 1'b0};
         default:    pc_d = pc_seq;
      endcase
   end

   assign dmem_addr  = sum;
   assign dmem_wdata = rs2_v;
   assign dmem_we    = ctrl.mem_wr;

   // R1: reset loads the start address
   a_r1_reset_pc: assert property (@(posedge clk)
      rst |=> (imem_addr == RESET_PC));

   // R4: a store never writes a register
   a_r4_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> !rf_we);

   // R9: sequential instructions advance by one word
   a_r9_seq_advance: assert property (@(posedge clk) disable iff (rst)
      (ctrl.npc_kind == NPK_SEQ) |=> (imem_addr == $past(imem_addr) + STEP));

   // R5: an untaken branch falls through
   a_r5_branch_fallthrough: assert property (@(posedge clk) disable iff (rst)
      (ctrl.npc_kind == NPK_BRANCH && rs1_v != rs2_v) |=> (imem_addr == $past(imem_addr) + STEP));

   // R7: the indirect jump target is always even
   a_r7_jalr_even: assert property (@(posedge clk) disable iff (rst)
      (ctrl.npc_kind == NPK_JALR) |=> (imem_addr[0] == 1'b0));

endmodule

// File: tb/rvs_core_tb_top.sv
module rvs_core_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] prog [64];
   logic [31:0] dm   [64];
   logic [31:0] mdm  [64];
   logic [31:0] mreg [32];
   string       regtag [32];
   logic [31:0] mpc;
   string       ptag;
   int          total = 0;
   int          bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign imem_rdata = prog[imem_addr[7:2]];
   assign dmem_rdata = dm[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

   rvs_core dut_i (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2, rs1, rd);
      return {f7, rs2, rs1, 3'b000, rd, 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
      return {im, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] rs2, rs1);
      return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] rs2, rs1);
      return {im[12], im[10:5], rs2, rs1, 3'b000, im[4:1], im[11], 7'b1100011};
   endfunction
   function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] rd);
      return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (pc=%h)", tag, act, exp, mpc);
      end
   endtask

   // Compare the outputs for the current instruction, then step the model.
   task automatic model_cycle();
      logic [31:0] ins;
      logic [6:0]  op;
      logic [2:0]  f3;
      logic [4:0]  rd, r1, r2;
      logic [31:0] a, b, ii, si, bi, ji, nxt, wv;
      bit          wr, st, ld;
      string       wt, ntag;
      ins = prog[mpc[7:2]];
      op = ins[6:0]; f3 = ins[14:12];
      rd = ins[11:7]; r1 = ins[19:15]; r2 = ins[24:20];
      a  = mreg[r1]; b = mreg[r2];
      ii = {{20{ins[31]}}, ins[31:20]};
      si = {{20{ins[31]}}, ins[31:25], ins[11:7]};
      bi = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      ji = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
      st = (op == 7'b0100011 && f3 == 3'b010);
      ld = (op == 7'b0000011 && f3 == 3'b010);

      chk(imem_addr == mpc, ptag, imem_addr, mpc);
      chk(dmem_we == st, st ? "R4" : "R9", {31'b0, dmem_we}, {31'b0, st});
      if (st) begin
         chk(dmem_addr == a + si, "R4", dmem_addr, a + si);
         chk(dmem_wdata == b, regtag[r2], dmem_wdata, b);
      end
      if (ld) chk(dmem_addr == a + ii, "R3", dmem_addr, a + ii);

      nxt = mpc + 32'd4; wr = 0; wv = '0; wt = "R2"; ntag = "R9";
      if (op == 7'b0110011 && f3 == 3'b000 && ins[31:25] == 7'b0) begin
         wr = 1; wv = a + b; wt = "R2";
      end else if (op == 7'b0010011 && f3 == 3'b000) begin
         wr = 1; wv = a + ii; wt = "R2";
      end else if (ld) begin
         wr = 1; wv = mdm[(a + ii) >> 2 & 32'h3f]; wt = "R3";
      end else if (st) begin
         mdm[(a + si) >> 2 & 32'h3f] = b; ntag = "R4";
      end else if (op == 7'b1100011 && f3 == 3'b000) begin
         if (a == b) nxt = mpc + bi;
         ntag = "R5";
      end else if (op == 7'b1101111) begin
         wr = 1; wv = mpc + 32'd4; wt = "R6"; nxt = mpc + ji; ntag = "R6";
      end else if (op == 7'b1100111 && f3 == 3'b000) begin
         wr = 1; wv = mpc + 32'd4; wt = "R7"; nxt = (a + ii) & ~32'd1; ntag = "R7";
      end
      if (wr && rd != 5'd0) begin
         mreg[rd] = wv; regtag[rd] = wt;
      end
      mpc = nxt; ptag = ntag;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < 64; i++) begin
         dm[i] = $urandom(); mdm[i] = dm[i]; prog[i] = 32'h0000_0013;
      end
      for (int i = 0; i < 32; i++) begin
         mreg[i] = '0; regtag[i] = (i == 0) ? "R8" : "R2";
      end
      // directed part
      prog[0]  = enc_i(12'd5, 5'd0, 3'b000, 5'd1, 7'b0010011);     // x1 = 5
      prog[1]  = enc_i(12'hffd, 5'd0, 3'b000, 5'd2, 7'b0010011);   // x2 = -3
      prog[2]  = enc_r(7'd0, 5'd2, 5'd1, 5'd3);                    // x3 = 2
      prog[3]  = enc_i(12'd7, 5'd0, 3'b000, 5'd0, 7'b0010011);     // R8 write to x0
      prog[4]  = enc_s(12'd16, 5'd0, 5'd0);                        // R8 store x0
      prog[5]  = enc_s(12'd21, 5'd3, 5'd0);                        // R3 low bits ignored
      prog[6]  = enc_i(12'd20, 5'd0, 3'b010, 5'd4, 7'b0000011);    // x4 = 2
      prog[7]  = enc_b(13'd8, 5'd3, 5'd4);                         // R5 taken
      prog[8]  = enc_i(12'd1, 5'd0, 3'b000, 5'd5, 7'b0010011);     // skipped
      prog[9]  = enc_b(13'd8, 5'd1, 5'd4);                         // R5 not taken
      prog[10] = enc_j(21'd8, 5'd6);                               // R6 x6 = 44
      prog[11] = enc_i(12'd2, 5'd0, 3'b000, 5'd5, 7'b0010011);     // skipped
      prog[12] = enc_i(12'd57, 5'd0, 3'b000, 5'd7, 7'b0010011);    // x7 = 57
      prog[13] = enc_i(12'd0, 5'd7, 3'b000, 5'd8, 7'b1100111);     // R7 to 56
      prog[14] = 32'h0000_007f;                                    // R9 unknown opcode
      prog[15] = enc_r(7'b0100000, 5'd2, 5'd1, 5'd4);              // R9 wrong funct7
      prog[16] = enc_s(12'd24, 5'd6, 5'd0);
      prog[17] = enc_s(12'd28, 5'd8, 5'd0);
      prog[18] = enc_s(12'd36, 5'd4, 5'd0);
      prog[19] = enc_i(12'd3, 5'd0, 3'b001, 5'd9, 7'b0010011);     // R9 wrong funct3
      for (int r = 9; r <= 15; r++)
         prog[20 + r - 9] = enc_i(12'($urandom()), 5'd0, 3'b000, 5'(r), 7'b0010011);
      // constrained random part
      for (int w = 27; w <= 60; w++) begin
         int k;
         logic [4:0] rd, r1, r2;
         k  = $urandom_range(0, 4);
         rd = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'(9 + $urandom_range(0, 6));
         r1 = 5'(9 + $urandom_range(0, 6));
         r2 = ($urandom_range(0, 1) == 0) ? r1 : 5'(9 + $urandom_range(0, 6));
         case (k)
            0: prog[w] = enc_i(12'($urandom()), r1, 3'b000, rd, 7'b0010011);
            1: prog[w] = enc_r(7'd0, r2, r1, rd);
            2: prog[w] = enc_s(12'($urandom_range(0, 255)), r2, 5'd0);
            3: prog[w] = enc_i(12'($urandom_range(0, 255)), 5'd0, 3'b010, rd, 7'b0000011);
            default: prog[w] = (w < 60) ? enc_b(13'd8, r2, r1)
                                        : enc_s(12'd40, r1, 5'd0);
         endcase
      end
      prog[61] = enc_j(21'd0, 5'd0);                               // spin in place

      repeat (2) @(posedge clk);
      @(negedge clk);
      mpc = 32'd0; ptag = "R1";
      chk(imem_addr == 32'd0, "R1", imem_addr, 32'd0);
      rst = 1'b0;
      for (int c = 0; c < 150; c++) begin
         model_cycle();
         @(negedge clk);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule